// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block is the bus-facing half of a small serial nonvolatile memory. It watches the clock and data lines of a two-wire bus through synchronizers running on a faster system clock. It recognises start and stop conditions and checks the device-select byte against a fixed device-type code and a strap pin. It acknowledges the bytes it accepts and works out which transaction the master is performing: byte write, page write, current read, random read or sequential read. It drives the data line only by pulling it low, so the line behaves as open drain.

Write traffic goes to a separate write controller. Each accepted data byte comes out with its target address, and a stop condition then tells the controller to commit the collected bytes. A repeated start before that stop tells it to discard them instead. For reads, the block presents an address on a simple memory port and takes the byte back combinationally. It keeps one internal word-address counter, which is shared by random, current and sequential reads.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, SDA is released. Until a start is seen, clocked bus traffic gets no acknowledge.
- R2: The device-select byte is, MSB first, the four bits 1010, then a bit equal to `strap_a2_i`, then 00, then the direction bit (1 = read). When the byte matches, SDA is pulled low for the ninth clock.
- R3: When the device-select byte does not match, SDA stays released for the rest of the transfer and the block waits for the next start.
- R4: In the write direction, the word-address byte and every data byte are acknowledged.
- R5: Each accepted data byte appears on `wr_stb_o` with its address. Within one transfer the address steps by one in its low PAGE_W bits and keeps its upper bits, so it wraps inside the page.
- R6: A stop after at least one data byte pulses `wr_commit_o`. A repeated start before that stop pulses `wr_drop_o` instead, and the data is not committed.
- R7: A random read (a write-direction address phase, a repeated start, then a read-direction select) returns the byte at the given word address.
- R8: While the master acknowledges, each read byte comes from the next address. The address wraps from the top of the space to 0.
- R9: After the master leaves a read acknowledge high, the block does not drive SDA again until a new start or stop.
- R10: A current read returns address n+1 after a read that ended at n. After a write whose last data byte went to n, it returns address n.
- R11: While `wr_busy_i` is high, the device-select byte is not acknowledged.
- R12: SDA changes only while SCL is low. Data is taken on SCL rising edges, and outgoing bits change after SCL falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a2_i | input | 1 | Strap selecting this device's select bit |
| wr_busy_i | input | 1 | Write controller is busy with a commit |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_stb_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr_o | output | ADDR_W | Target address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse: commit the collected bytes |
| wr_drop_o | output | 1 | One-cycle pulse: discard the collected bytes |
| rd_addr_o | output | ADDR_W | Memory read address (word-address counter) |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, combinational |

## Verification
The bench builds the block with its defaults: an 8-bit word address, 3-bit pages and two synchronizer stages, with the strap tied high. With these values, a few bytes starting near the top of the 256-byte space reach the wrap from 0xFF to 0x00. A four-byte page write starting at 0x1E crosses the end of its eight-byte page. Because the strap is high, a select byte whose strap bit is 0 is a genuine mismatch.

// File: rtl/twi_slv_pkg.sv
`timescale 1ns/1ps
package twi_slv_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_HOLD
   } slv_state_e;

   typedef enum logic [1:0] {
      K_DEV, K_WA, K_DAT
   } rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_lvl   = scl_sh[STAGES-1];
   assign sda_lvl   = sda_sh[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/twi_word_ptr.sv
`timescale 1ns/1ps
module twi_word_ptr #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              wr_step,
   input  logic              rd_step,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_ptr
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   logic [ADDR_W-1:0] ptr_nxt;

   if (PAGE_W >= ADDR_W) begin : g_flat
      assign ptr_nxt = wr_ptr + ONE_A;
   end else begin : g_paged
      localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
      assign ptr_nxt = {wr_ptr[ADDR_W-1:PAGE_W], wr_ptr[PAGE_W-1:0] + ONE_P};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr <= '0;
         wr_ptr  <= '0;
      end else if (load) begin
         rd_addr <= load_val;
         wr_ptr  <= load_val;
      end else if (wr_step) begin
         rd_addr <= wr_ptr;
         wr_ptr  <= ptr_nxt;
      end else if (rd_step) begin
         rd_addr <= rd_addr + ONE_A;
      end
   end
endmodule

// File: rtl/twi_eeprom_slave.sv
`timescale 1ns/1ps
module twi_eeprom_slave
   import twi_slv_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 3,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_ID      = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_a2_i,
   input  logic              wr_busy_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_commit_o,
   output logic              wr_drop_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i
);
   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
      $error("twi_eeprom_slave: ADDR_W must lie in 1..8");
   end
   if (PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_page
      $error("twi_eeprom_slave: PAGE_W must lie in 1..ADDR_W");
   end

   localparam logic [CNT_W-1:0] BIT_N = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   slv_state_e        state_q;
   rx_kind_e          kind_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        rx_q, tx_q;
   logic              oe_q, rw_q, mack_q, pend_q;
   logic              stb_q, commit_q, drop_q;
   logic [ADDR_W-1:0] waddr_q, wr_ptr;
   logic [7:0]        wdata_q;
   logic              byte_end, dev_hit, ptr_load, ptr_wr, ptr_rd;
   logic              st_idle, st_read;

   assign byte_end = scl_fall && (cnt_q == BIT_N);
   assign dev_hit  = (rx_q[7:1] == {DEV_ID, strap_a2_i, 2'b00}) && !wr_busy_i;
   assign ptr_load = (state_q == ST_RX) && byte_end && (kind_q == K_WA);
   assign ptr_wr   = (state_q == ST_RX) && byte_end && (kind_q == K_DAT);
   assign ptr_rd   = (state_q == ST_TX) && byte_end;
   assign st_idle  = (state_q == ST_IDLE);
   assign st_read  = (state_q == ST_TX) || (state_q == ST_MACK);

   twi_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_q[ADDR_W-1:0]),
      .wr_step(ptr_wr), .rd_step(ptr_rd), .rd_addr(rd_addr_o), .wr_ptr(wr_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= K_DEV;
         cnt_q    <= '0;
         rx_q     <= '0;
         tx_q     <= '0;
         oe_q     <= 1'b0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         pend_q   <= 1'b0;
         stb_q    <= 1'b0;
         commit_q <= 1'b0;
         drop_q   <= 1'b0;
         waddr_q  <= '0;
         wdata_q  <= '0;
      end else begin
         stb_q    <= 1'b0;
         commit_q <= 1'b0;
         drop_q   <= 1'b0;
         if (stop_det) begin
            state_q  <= ST_IDLE;
            oe_q     <= 1'b0;
            commit_q <= pend_q;
            pend_q   <= 1'b0;
         end else if (start_det) begin
            state_q <= ST_RX;
            kind_q  <= K_DEV;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            drop_q  <= pend_q;
            pend_q  <= 1'b0;
         end else begin
            unique case (state_q)
               ST_RX: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[6:0], sda_lvl};
                     cnt_q <= cnt_q + ONE_C;
                  end else if (byte_end) begin
                     if (kind_q == K_DEV) begin
                        if (dev_hit) begin
                           oe_q    <= 1'b1;
                           rw_q    <= rx_q[0];
                           state_q <= ST_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else begin
                        oe_q    <= 1'b1;
                        state_q <= ST_ACK;
                        if (kind_q == K_DAT) begin
                           stb_q   <= 1'b1;
                           pend_q  <= 1'b1;
                           waddr_q <= wr_ptr;
                           wdata_q <= rx_q;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (kind_q == K_DEV && rw_q) begin
                        tx_q    <= rd_data_i;
                        oe_q    <= ~rd_data_i[7];
                        state_q <= ST_TX;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RX;
                        kind_q  <= (kind_q == K_DEV) ? K_WA : K_DAT;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + ONE_C;
                  end else if (byte_end) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_MACK;
                  end else if (scl_fall) begin
                     tx_q <= {tx_q[6:0], 1'b0};
                     oe_q <= ~tx_q[6];
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q    <= rd_data_i;
                        oe_q    <= ~rd_data_i[7];
                        cnt_q   <= '0;
                        state_q <= ST_TX;
                     end else begin
                        state_q <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign wr_stb_o    = stb_q;
   assign wr_addr_o   = waddr_q;
   assign wr_data_o   = wdata_q;
   assign wr_commit_o = commit_q;
   assign wr_drop_o   = drop_q;
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
`timescale 1ns/1ps
module twi_eeprom_slave_chk #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe_o,
   input logic              wr_stb_o,
   input logic              wr_commit_o,
   input logic              wr_drop_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              st_idle,
   input logic              st_read
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   logic              seen_q;
   logic [ADDR_W-1:0] last_q, exp_nxt;

   if (PAGE_W >= ADDR_W) begin : g_flat
      assign exp_nxt = last_q + ONE_A;
   end else begin : g_paged
      localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
      assign exp_nxt = {last_q[ADDR_W-1:PAGE_W], last_q[PAGE_W-1:0] + ONE_P};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (wr_commit_o || wr_drop_o || st_idle) begin
         seen_q <= 1'b0;
      end else if (wr_stb_o) begin
         seen_q <= 1'b1;
         last_q <= wr_addr_o;
      end
   end

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      st_idle |-> !sda_oe_o); // R1

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i); // R12

   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_o && seen_q) |-> (wr_addr_o == exp_nxt)); // R5

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_stb_o, wr_commit_o, wr_drop_o})); // R6

   AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_read && $past(st_read) && (rd_addr_o != $past(rd_addr_o)))
      |-> (rd_addr_o == $past(rd_addr_o) + ONE_A)); // R8
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .wr_stb_o(wr_stb_o), .wr_commit_o(wr_commit_o), .wr_drop_o(wr_drop_o),
   .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o),
   .st_idle(st_idle), .st_read(st_read)
);

// File: tb/test_twi_eeprom_slave.sv
`timescale 1ns/1ps
module test_twi_eeprom_slave;
   localparam int Q = 64;
   localparam logic [7:0] SEL_W = 8'hA8;
   localparam logic [7:0] SEL_R = 8'hA9;
   localparam logic [15:0] VEC [0:5] = '{
      16'h0300, 16'h40FF, 16'h7F3C, 16'h80C3, 16'hC196, 16'hFD5A
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic busy = 1'b0;
   logic sda_oe, wr_stb, wr_commit, wr_drop;
   logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
   logic sda_line;

   int errs = 0;
   int checks = 0;
   int r12_bad = 0;
   logic done = 1'b0;
   logic ak;
   logic [7:0] b;

   always #2 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   twi_eeprom_slave i_twi_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .strap_a2_i(1'b1), .wr_busy_i(busy),
      .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .wr_commit_o(wr_commit), .wr_drop_o(wr_drop),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data)
   );

   // memory and write-controller model
   logic [7:0] mem [256];
   logic [7:0] pa [16];
   logic [7:0] pd [16];
   int pn;
   assign rd_data = mem[rd_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 256; k++) mem[k] <= 8'(k) ^ 8'hA5;
         pn <= 0;
      end else begin
         if (wr_stb && pn < 16) begin
            pa[pn] <= wr_addr;
            pd[pn] <= wr_data;
            pn <= pn + 1;
         end
         if (wr_commit) begin
            for (int k = 0; k < pn; k++) mem[pa[k]] <= pd[k];
            pn <= 0;
         end
         if (wr_drop) pn <= 0;
      end
   end

   logic oe_prev = 1'b0;
   always @(posedge clk) begin
      if (rst_n && (sda_oe != oe_prev) && m_scl) r12_bad++;
      oe_prev <= sda_oe;
   end

   function automatic logic [7:0] init_v(input logic [7:0] a);
      return a ^ 8'hA5;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_scl = 1'b0; #(Q);
      m_sda = 1'b1; #(Q);
      m_scl = 1'b1; #(Q);
      m_sda = 1'b0; #(Q);
      m_scl = 1'b0;
   endtask

   task automatic bus_stop();
      m_scl = 1'b0; #(Q);
      m_sda = 1'b0; #(Q);
      m_scl = 1'b1; #(Q);
      m_sda = 1'b1; #(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_scl = 1'b0; #(Q);
         m_sda = v[i]; #(Q);
         m_scl = 1'b1; #(2*Q);
      end
      m_scl = 1'b0; #(Q);
      m_sda = 1'b1; #(Q);
      m_scl = 1'b1; #(Q);
      acked = ~sda_line; #(Q);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         m_scl = 1'b0; #(Q);
         m_sda = 1'b1; #(Q);
         m_scl = 1'b1; #(Q);
         v[i] = sda_line; #(Q);
      end
      m_scl = 1'b0; #(Q);
      m_sda = ~give_ack; #(Q);
      m_scl = 1'b1; #(2*Q);
   endtask

   task automatic random_read(input logic [7:0] a, output logic [7:0] v);
      logic k;
      bus_start();
      send_byte(SEL_W, k);
      send_byte(a, k);
      bus_start();
      send_byte(SEL_R, k);
      recv_byte(1'b0, v);
      bus_stop();
   endtask

   initial begin
      #(400_000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset sda released", int'(sda_oe), 0);
      chk("R1 reset no strobe", int'(wr_stb), 0);

      // R1: traffic before any start is ignored
      send_byte(SEL_W, ak);
      chk("R1 no ack without start", int'(ak), 0);
      bus_stop();

      // vector table: byte write then random read back (R2 R4 R6 R7)
      for (int v = 0; v < 6; v++) begin
         logic [7:0] a, d;
         a = VEC[v][15:8];
         d = VEC[v][7:0];
         bus_start();
         send_byte(SEL_W, ak);
         chk("R2 select ack", int'(ak), 1);
         send_byte(a, ak);
         chk("R4 word address ack", int'(ak), 1);
         send_byte(d, ak);
         chk("R4 data ack", int'(ak), 1);
         bus_stop();
         random_read(a, b);
         chk("R7 R6 random read of written byte", int'(b), int'(d));
      end

      // R3: strap bit mismatch, then stays released
      bus_start();
      send_byte(8'hA0, ak);
      chk("R3 strap mismatch no ack", int'(ak), 0);
      send_byte(8'h00, ak);
      chk("R3 released after mismatch", int'(ak), 0);
      bus_stop();

      // R2: wrong device-type code
      bus_start();
      send_byte(8'hB8, ak);
      chk("R2 wrong type code no ack", int'(ak), 0);
      bus_stop();

      // R11: busy write controller
      busy = 1'b1;
      bus_start();
      send_byte(SEL_W, ak);
      chk("R11 no select ack while busy", int'(ak), 0);
      bus_stop();
      busy = 1'b0;

      // R5: page write crossing the page end
      bus_start();
      send_byte(SEL_W, ak);
      send_byte(8'h1E, ak);
      send_byte(8'h11, ak);
      send_byte(8'h22, ak);
      send_byte(8'h33, ak);
      send_byte(8'h44, ak);
      chk("R4 last page data ack", int'(ak), 1);
      bus_stop();

      // R10: current read after write returns last written address
      bus_start();
      send_byte(SEL_R, ak);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R10 current read after write", int'(b), 8'h44);
      bus_start();
      send_byte(SEL_R, ak);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R10 current read after read", int'(b), int'(init_v(8'h1A)));

      random_read(8'h1E, b);
      chk("R5 page byte at 1E", int'(b), 8'h11);
      random_read(8'h1F, b);
      chk("R5 page byte at 1F", int'(b), 8'h22);
      random_read(8'h18, b);
      chk("R5 page wrapped to 18", int'(b), 8'h33);
      random_read(8'h20, b);
      chk("R5 next page untouched", int'(b), int'(init_v(8'h20)));

      // R8 sequential read across the top, R9 master NACK
      bus_start();
      send_byte(SEL_W, ak);
      send_byte(8'hFE, ak);
      bus_start();
      send_byte(SEL_R, ak);
      recv_byte(1'b1, b);
      chk("R8 seq byte FE", int'(b), int'(init_v(8'hFE)));
      recv_byte(1'b1, b);
      chk("R8 seq byte FF", int'(b), int'(init_v(8'hFF)));
      recv_byte(1'b1, b);
      chk("R8 seq wrap to 00", int'(b), int'(init_v(8'h00)));
      recv_byte(1'b0, b);
      chk("R8 seq byte 01", int'(b), int'(init_v(8'h01)));
      recv_byte(1'b0, b);
      chk("R9 line released after nack", int'(b), 8'hFF);
      bus_stop();
      bus_start();
      send_byte(SEL_R, ak);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R10 current read continues at n+1", int'(b), int'(init_v(8'h02)));

      // R6: repeated start discards pending data
      bus_start();
      send_byte(SEL_W, ak);
      send_byte(8'h50, ak);
      send_byte(8'h11, ak);
      bus_start();
      bus_stop();
      random_read(8'h50, b);
      chk("R6 dropped write not committed", int'(b), int'(init_v(8'h50)));

      chk("R12 sda changed only with scl low", r12_bad, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule